// File: doc/BRIEF.md
# Reconfigurable Cell Datapath

This block is one processing element of a coarse-grained reconfigurable array. Every clock cycle it receives a context word that tells it what to do in that cycle. Three operand multiplexers pick values from a common set of sources: the cell's four internal registers, the shared frame-buffer data port and three ports that carry neighbouring cells' outputs. The cell applies one arithmetic, logic, shift or bit-reduction operation to those values. It can store the result in one internal register, in the registered output that the neighbours read, or in both.

The operation set includes the usual add, subtract, bitwise and shift operations. It also has a multiply-by-signed-constant-then-add, a population count of the low byte, and two additions aimed at cipher kernels: a single-cycle parity of the low byte and a three-input XOR. The context memory, the interconnect, the frame buffer and the host that sequences contexts sit outside this block. They appear only as ports.

Top module: `rc_cell`

## Requirements
- R1: After reset, all four internal registers and the cell output are zero.
- R2: The context word holds these fields, most significant first: opcode [28:25], source A [24:22], source B [21:19], source C [18:16], destination register [15:14], register write enable [13], output enable [12], shift amount [11:8], constant [7:0]. Source codes 0 to 3 select registers 0 to 3, code 4 selects the frame-buffer port, and codes 5, 6 and 7 select neighbour ports 0, 1 and 2. Neighbour port n occupies bits [16n+15:16n] of the neighbour bus.
- R3: Opcode 1 passes A through. Opcodes 2 and 3 give A+B and A−B modulo 2^16. Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of A and B.
- R4: Opcode 8 shifts A left by the shift amount (0 to 15). Opcode 9 shifts A right logically by the shift amount. Vacated bits are filled with zeros.
- R5: Opcode 10 gives (A × sign-extended constant) truncated to 16 bits, plus B, modulo 2^16.
- R6: Opcode 11 gives the number of one bits in A[7:0]. A[15:8] has no effect.
- R7: Opcode 12 gives the XOR of the bits of A[7:0] in bit 0, with bits 15:1 equal to zero.
- R8: Opcode 7 gives A XOR B XOR C.
- R9: For opcodes 1 to 12, the result goes to the destination register only when write enable is 1, and to the cell output only when output enable is 1. Both updates appear on the clock edge that ends the cycle. Operands read in that cycle see the register values from before the write. Registers that are not written keep their values.
- R10: Opcode 0 and the unused opcodes 13 to 15 leave every register and the output unchanged, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctx_i | input | 29 | Context word for the current cycle |
| fb_data_i | input | 16 | Frame-buffer data operand |
| nbr_data_i | input | 48 | Three neighbour-cell outputs, packed |
| cell_out_o | output | 16 | Registered cell output |

## Verification
The bench builds the cell with its defaults: a 16-bit datapath and three neighbour ports. With these values a four-bit shift field covers every shift distance from 0 to 15. The eight-bit constant also runs over its whole signed range, so the multiply-add is exercised with both positive and negative constants and with products that are truncated. Because the select field is three bits wide, every one of its codes names a real source, and a loop over the codes reaches every register, the frame-buffer port and every neighbour port.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int OP_W   = 4;
    localparam int SEL_W  = 3;
    localparam int DST_W  = 2;
    localparam int C_W    = 8;
    localparam int BYTE_W = 8;
    localparam int NREG   = 1 << DST_W;

    localparam logic [OP_W-1:0] OP_NOP    = 4'd0;
    localparam logic [OP_W-1:0] OP_PASS   = 4'd1;
    localparam logic [OP_W-1:0] OP_ADD    = 4'd2;
    localparam logic [OP_W-1:0] OP_SUB    = 4'd3;
    localparam logic [OP_W-1:0] OP_AND    = 4'd4;
    localparam logic [OP_W-1:0] OP_OR     = 4'd5;
    localparam logic [OP_W-1:0] OP_XOR    = 4'd6;
    localparam logic [OP_W-1:0] OP_XOR3   = 4'd7;
    localparam logic [OP_W-1:0] OP_SHL    = 4'd8;
    localparam logic [OP_W-1:0] OP_SHR    = 4'd9;
    localparam logic [OP_W-1:0] OP_MULADD = 4'd10;
    localparam logic [OP_W-1:0] OP_POPC   = 4'd11;
    localparam logic [OP_W-1:0] OP_PAR    = 4'd12;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
        logic [SEL_W-1:0] sel_c;
        logic [DST_W-1:0] dst;
        logic             wr_en;
        logic             out_en;
    } ctx_ctrl_t;
endpackage

// File: rtl/rc_opmux.sv
module rc_opmux
    import rc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NNBR   = 3
) (
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [NREG*DATA_W-1:0] regs_i,
    input  logic [DATA_W-1:0]      fb_i,
    input  logic [NNBR*DATA_W-1:0] nbr_i,
    output logic [DATA_W-1:0]      opnd_o
);
    localparam int FB_CODE = NREG;

    always_comb begin
        opnd_o = '0;
        for (int k = 0; k < NREG; k++) begin
            if (sel_i == SEL_W'(k)) opnd_o = regs_i[k*DATA_W +: DATA_W];
        end
        if (sel_i == SEL_W'(FB_CODE)) opnd_o = fb_i;
        for (int k = 0; k < NNBR; k++) begin
            if (sel_i == SEL_W'(FB_CODE + 1 + k)) opnd_o = nbr_i[k*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/rc_shifter.sv
module rc_shifter #(
    parameter int DATA_W = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [SH_W-1:0]   amt_i,
    input  logic              left_i,
    output logic [DATA_W-1:0] val_o
);
    logic [DATA_W-1:0] stage [SH_W+1];

    assign stage[0] = val_i;

    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        always_comb begin
            if (!amt_i[g])
                stage[g+1] = stage[g];
            else if (left_i)
                stage[g+1] = stage[g] << (1 << g);
            else
                stage[g+1] = stage[g] >> (1 << g);
        end
    end

    assign val_o = stage[SH_W];
endmodule

// File: rtl/rc_alu.sv
module rc_alu
    import rc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] c_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [C_W-1:0]    konst_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] konst_ext;
    logic [DATA_W-1:0] product;
    logic [CNT_W-1:0]  ones;

    rc_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) shifter_i (
        .val_i  (a_i),
        .amt_i  (shamt_i),
        .left_i (op_i == OP_SHL),
        .val_o  (shifted)
    );

    assign konst_ext = {{(DATA_W-C_W){konst_i[C_W-1]}}, konst_i};
    assign product   = a_i * konst_ext;

    always_comb begin
        ones = '0;
        for (int i = 0; i < BYTE_W; i++) ones = ones + CNT_W'(a_i[i]);
    end

    always_comb begin
        unique case (op_i)
            OP_PASS:   res_o = a_i;
            OP_ADD:    res_o = a_i + b_i;
            OP_SUB:    res_o = a_i - b_i;
            OP_AND:    res_o = a_i & b_i;
            OP_OR:     res_o = a_i | b_i;
            OP_XOR:    res_o = a_i ^ b_i;
            OP_XOR3:   res_o = a_i ^ b_i ^ c_i;
            OP_SHL,
            OP_SHR:    res_o = shifted;
            OP_MULADD: res_o = product + b_i;
            OP_POPC:   res_o = DATA_W'(ones);
            OP_PAR:    res_o = {{(DATA_W-1){1'b0}}, ^a_i[BYTE_W-1:0]};
            default:   res_o = '0;
        endcase
    end
endmodule

// File: rtl/rc_cell.sv
module rc_cell
    import rc_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int NNBR   = 3,
    localparam int SH_W   = $clog2(DATA_W),
    localparam int CTX_W  = OP_W + 3*SEL_W + DST_W + 2 + SH_W + C_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [CTX_W-1:0]       ctx_i,
    input  logic [DATA_W-1:0]      fb_data_i,
    input  logic [NNBR*DATA_W-1:0] nbr_data_i,
    output logic [DATA_W-1:0]      cell_out_o
);
    localparam int SH_LSB   = C_W;
    localparam int CTRL_LSB = SH_LSB + SH_W;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] rf;
        logic [DATA_W-1:0]           out;
    } cell_state_t;

    cell_state_t st_d, st_q;
    ctx_ctrl_t   ctrl;
    logic [SH_W-1:0]   shamt;
    logic [C_W-1:0]    konst;
    logic [DATA_W-1:0] opnd_a, opnd_b, opnd_c, alu_res;
    logic              op_valid;

    assign konst = ctx_i[C_W-1:0];
    assign shamt = ctx_i[SH_LSB +: SH_W];
    assign ctrl  = ctx_i[CTX_W-1:CTRL_LSB];
    assign op_valid = (ctrl.op != OP_NOP) && (ctrl.op <= OP_PAR);

    logic [SEL_W-1:0] sel_vec [3];
    logic [DATA_W-1:0] opnd_vec [3];
    assign sel_vec[0] = ctrl.sel_a;
    assign sel_vec[1] = ctrl.sel_b;
    assign sel_vec[2] = ctrl.sel_c;

    for (genvar m = 0; m < 3; m++) begin : g_mux
        rc_opmux #(.DATA_W(DATA_W), .NNBR(NNBR)) mux_i (
            .sel_i  (sel_vec[m]),
            .regs_i (st_q.rf),
            .fb_i   (fb_data_i),
            .nbr_i  (nbr_data_i),
            .opnd_o (opnd_vec[m])
        );
    end

    assign opnd_a = opnd_vec[0];
    assign opnd_b = opnd_vec[1];
    assign opnd_c = opnd_vec[2];

    rc_alu #(.DATA_W(DATA_W), .SH_W(SH_W)) alu_i (
        .op_i    (ctrl.op),
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .c_i     (opnd_c),
        .shamt_i (shamt),
        .konst_i (konst),
        .res_o   (alu_res)
    );

    // R6 / R7: reduction results stay in their ranges
    p_popc_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl.op == OP_POPC) |-> (alu_res <= DATA_W'(BYTE_W)));
    p_par_single_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl.op == OP_PAR) |-> (alu_res[DATA_W-1:1] == '0));

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            if (ctrl.wr_en)  st_d.rf[ctrl.dst] = alu_res;
            if (ctrl.out_en) st_d.out = alu_res;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cell_out_o = st_q.out;

    // R9: output follows the result only when enabled
    p_out_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid && ctrl.out_en) |=> (cell_out_o == $past(alu_res)));
    p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(op_valid && ctrl.out_en) |=> $stable(cell_out_o));

    // R9: registers that are not the write target keep their values
    for (genvar k = 0; k < NREG; k++) begin : g_rf_chk
        p_rf_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(op_valid && ctrl.wr_en && ctrl.dst == DST_W'(k)) |=> $stable(st_q.rf[k]));
    end

    // R10: no-op and unused codes freeze all state
    p_nop_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid |=> $stable(st_q));
endmodule

// File: tb/rc_cell_tb_top.sv
module rc_cell_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] ctx = '0;
    logic [15:0] fb = '0;
    logic [15:0] nb [3];
    logic [47:0] nbr_bus;
    logic [15:0] cell_out;
    logic [15:0] mdl_rf [4];
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    assign nbr_bus = {nb[2], nb[1], nb[0]};

    always #2 clk = ~clk;

    rc_cell dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ctx_i      (ctx),
        .fb_data_i  (fb),
        .nbr_data_i (nbr_bus),
        .cell_out_o (cell_out)
    );

    function automatic logic [28:0] mk(input logic [3:0] op, input logic [2:0] sa, input logic [2:0] sb,
                                       input logic [2:0] sc, input logic [1:0] dst, input logic we,
                                       input logic oe, input logic [3:0] sh, input logic [7:0] k);
        return {op, sa, sb, sc, dst, we, oe, sh, k};
    endfunction

    function automatic logic [15:0] src_val(input logic [2:0] s);
        if (s < 3'd4) return mdl_rf[s[1:0]];
        if (s == 3'd4) return fb;
        return nb[s - 3'd5];
    endfunction

    function automatic logic [15:0] ref_res(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                                            input logic [15:0] c, input logic [3:0] sh, input logic [7:0] k);
        logic [15:0] r;
        logic [15:0] kx;
        kx = {{8{k[7]}}, k};
        case (op)
            4'd1:  r = a;
            4'd2:  r = a + b;
            4'd3:  r = a - b;
            4'd4:  r = a & b;
            4'd5:  r = a | b;
            4'd6:  r = a ^ b;
            4'd7:  r = a ^ b ^ c;
            4'd8:  r = a << sh;
            4'd9:  r = a >> sh;
            4'd10: begin r = a * kx; r = r + b; end
            4'd11: begin r = '0; for (int i = 0; i < 8; i++) r = r + 16'(a[i]); end
            4'd12: r = {15'b0, ^a[7:0]};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [28:0] c);
        @(negedge clk);
        ctx = c;
        @(negedge clk);
        ctx = '0;
    endtask

    task automatic load_reg(input logic [1:0] r, input logic [15:0] v);
        fb = v;
        run(mk(4'd1, 3'd4, 3'd0, 3'd0, r, 1'b1, 1'b0, 4'd0, 8'd0));
        mdl_rf[r] = v;
    endtask

    task automatic read_reg(input logic [1:0] r, input string tag);
        run(mk(4'd1, {1'b0, r}, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 4'd0, 8'd0));
        chk(tag, cell_out, mdl_rf[r]);
    endtask

    task automatic one_op(input logic [3:0] op, input logic [2:0] sa, input logic [2:0] sb,
                          input logic [2:0] sc, input logic [3:0] sh, input logic [7:0] k, input string tag);
        logic [15:0] e;
        e = ref_res(op, src_val(sa), src_val(sb), src_val(sc), sh, k);
        run(mk(op, sa, sb, sc, 2'd0, 1'b0, 1'b1, sh, k));
        chk(tag, cell_out, e);
    endtask

    task automatic test_reset;
        chk("R1 output after reset", cell_out, 16'h0000);
        for (int r = 0; r < 4; r++) begin
            mdl_rf[r] = '0;
            read_reg(2'(r), "R1 register after reset");
        end
    endtask

    task automatic test_sources;
        load_reg(2'd0, 16'h1111); load_reg(2'd1, 16'h2222);
        load_reg(2'd2, 16'h3333); load_reg(2'd3, 16'h4444);
        fb = 16'hF00D; nb[0] = 16'hA0A0; nb[1] = 16'hB1B1; nb[2] = 16'hC2C2;
        for (int s = 0; s < 8; s++) begin
            one_op(4'd1, 3'(s), 3'd0, 3'd0, 4'd0, 8'd0, "R2 source select");
        end
    endtask

    task automatic test_random_ops;
        logic [3:0] ops [12] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12};
        string tags [12] = '{"R3 pass", "R3 add", "R3 sub", "R3 and", "R3 or", "R3 xor", "R8 xor3",
                             "R4 shl", "R4 shr", "R5 muladd", "R6 popcount", "R7 parity"};
        for (int r = 0; r < 4; r++) load_reg(2'(r), 16'($urandom));
        for (int i = 0; i < 12; i++) begin
            for (int s = 0; s < 8; s++) begin
                fb = 16'($urandom); nb[0] = 16'($urandom); nb[1] = 16'($urandom); nb[2] = 16'($urandom);
                one_op(ops[i], 3'(s), 3'($urandom), 3'($urandom), 4'($urandom), 8'($urandom), tags[i]);
            end
        end
    endtask

    task automatic test_shift_edges;
        fb = 16'h8001;
        run(mk(4'd8, 3'd4, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 4'd15, 8'd0));
        chk("R4 shl by 15", cell_out, 16'h8000);
        run(mk(4'd9, 3'd4, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 4'd15, 8'd0));
        chk("R4 shr by 15", cell_out, 16'h0001);
        run(mk(4'd9, 3'd4, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 4'd0, 8'd0));
        chk("R4 shift by 0", cell_out, 16'h8001);
    endtask

    task automatic test_muladd;
        fb = 16'd3; nb[0] = 16'd10;
        run(mk(4'd10, 3'd4, 3'd5, 3'd0, 2'd0, 1'b0, 1'b1, 4'd0, 8'hFE));
        chk("R5 negative constant", cell_out, 16'h0004);
        fb = 16'h1234; nb[0] = 16'h0000;
        run(mk(4'd10, 3'd4, 3'd5, 3'd0, 2'd0, 1'b0, 1'b1, 4'd0, 8'h7F));
        chk("R5 truncated product", cell_out, 16'h07CC);
    endtask

    task automatic test_byte_reduce;
        fb = 16'hFF00; run(mk(4'd11, 3'd4, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 4'd0, 8'd0));
        chk("R6 upper byte ignored", cell_out, 16'd0);
        fb = 16'h00FF; run(mk(4'd11, 3'd4, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 4'd0, 8'd0));
        chk("R6 full byte", cell_out, 16'd8);
        fb = 16'h0003; run(mk(4'd12, 3'd4, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 4'd0, 8'd0));
        chk("R7 even parity", cell_out, 16'd0);
        fb = 16'hFF80; run(mk(4'd12, 3'd4, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, 4'd0, 8'd0));
        chk("R7 odd parity", cell_out, 16'd1);
    endtask

    task automatic test_writeback;
        load_reg(2'd0, 16'h0101); load_reg(2'd1, 16'h0202);
        load_reg(2'd2, 16'h0303); load_reg(2'd3, 16'h0404);
        fb = 16'h0010;
        run(mk(4'd2, 3'd1, 3'd4, 3'd0, 2'd1, 1'b1, 1'b1, 4'd0, 8'd0));
        chk("R9 operand reads old value", cell_out, 16'h0212);
        mdl_rf[1] = 16'h0212;
        read_reg(2'd1, "R9 destination written");
        read_reg(2'd0, "R9 other register kept");
        read_reg(2'd2, "R9 other register kept");
        read_reg(2'd3, "R9 other register kept");
        run(mk(4'd6, 3'd4, 3'd4, 3'd0, 2'd3, 1'b0, 1'b1, 4'd0, 8'd0));
        chk("R9 output without write", cell_out, 16'h0000);
        read_reg(2'd3, "R9 write enable low");
        fb = 16'h5A5A;
        run(mk(4'd1, 3'd4, 3'd0, 3'd0, 2'd2, 1'b1, 1'b0, 4'd0, 8'd0));
        chk("R9 output enable low", cell_out, 16'h0404);
        mdl_rf[2] = 16'h5A5A;
        read_reg(2'd2, "R9 write without output");
    endtask

    task automatic test_nop;
        logic [15:0] held;
        held = cell_out;
        fb = 16'hDEAD;
        run(mk(4'd0, 3'd4, 3'd4, 3'd4, 2'd0, 1'b1, 1'b1, 4'd3, 8'h55));
        chk("R10 nop output", cell_out, held);
        run(mk(4'd14, 3'd4, 3'd4, 3'd4, 2'd0, 1'b1, 1'b1, 4'd3, 8'h55));
        chk("R10 unused opcode output", cell_out, held);
        run(mk(4'd15, 3'd4, 3'd4, 3'd4, 2'd0, 1'b1, 1'b1, 4'd3, 8'h55));
        chk("R10 unused opcode output", cell_out, held);
        read_reg(2'd0, "R10 register unchanged");
    endtask

    initial begin
        nb[0] = '0; nb[1] = '0; nb[2] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_sources;
        test_random_ops;
        test_shift_edges;
        test_muladd;
        test_byte_reduce;
        test_writeback;
        test_nop;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule